// File: doc/BRIEF.md
# Low-Power Real-Time Clock with Alarm

This peripheral keeps wall-clock time in a slow, always-on clock domain and is programmed from a fast register clock. A free-running sub-second counter advances on every slow-clock cycle. A 32-bit seconds counter steps each time the sub-second counter wraps, but only after software has taken the block through two ordered exits: first out of the init state, then out of the non-valid state. The second exit is accepted only while a power-glitch register holds its expected magic value.

Every bus write is placed in a holding register and handed to the slow domain through a toggle handshake. A busy flag turns away further writes until the slow domain has applied the pending one. All slow-domain state is copied back to the bus side on a synchronised per-cycle tick, so reads are coherent snapshots. An alarm compare sets a status flag that drives an interrupt line and a wakeup line, each under its own enable.

The slow clock must be at least four times slower than the bus clock.

Top module: `lp_rtc`

## Requirements
- R1: After reset, wr_busy, alarm_irq and alarm_wake are low, and the status (offset 0x14), control (0x10) and seconds (0x00) registers read 0.
- R2: A write is taken only while wr_busy is low. wr_busy is high from the cycle after a taken write until that write has been applied, and a write offered while busy has no effect.
- R3: The alarm (0x08), seconds (0x00) and glitch (0x18) registers read back the full 32-bit value written. Control (0x10) keeps only bits 15, 14, 11, 7, 4 and 3, and every other bit reads 0.
- R4: A control write with bits 15 and 11 both set sets status bit 15 (init exited). A control write with only bit 15 set does not.
- R5: Status bit 14 (non-valid exited) sets on a control write with bits 15, 14, 11 and 3 all set. This happens only when status bit 15 is already set and the glitch register holds 0x41736166.
- R6: The sub-second counter (0x04) increases by 1 on every slow-clock cycle, wrapping at 2^SUB_W. Seconds increments on each wrap only while status bit 14 and control bit 3 are both set, and holds otherwise.
- R7: Once status bit 14 is set, status bit 3 (alarm flag) sets in the cycle where seconds becomes equal to the alarm register.
- R8: Writing a 1 to status bit 3 clears the alarm flag. Writing 1s to status bits 14 and 15 leaves them set, because only lp_rst clears them.
- R9: alarm_irq is high one slow cycle after the alarm flag and control bit 7 are both set. alarm_wake is high one slow cycle after the flag and control bit 4 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register (bus) clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| lp_clk | input | 1 | Slow always-on clock |
| lp_rst | input | 1 | Synchronous active-high power-on reset, slow domain |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | DATA_W | Write data |
| wr_busy | output | 1 | A write is still in flight |
| rd_en | input | 1 | Read strobe; rd_data updates on the next edge |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | DATA_W | Registered read data |
| alarm_irq | output | 1 | Alarm interrupt request |
| alarm_wake | output | 1 | Alarm wakeup request |

## Verification
If the sequencing state is wrong, the status readback shows it within a few slow cycles of the control write. A seconds counter that runs too early or too late shows up as a wrong difference between two seconds reads taken exactly 2^SUB_W slow cycles apart. A broken handshake shows up as a lost or doubled write on the next readback. An alarm flag that is wrong reaches alarm_irq and alarm_wake one slow cycle later, and the status read shows it at once.

// File: rtl/lp_rtc_pkg.sv
`timescale 1ns/1ps
package lp_rtc_pkg;
  localparam int OFS_SEC   = 'h00;
  localparam int OFS_SUB   = 'h04;
  localparam int OFS_ALARM = 'h08;
  localparam int OFS_CTRL  = 'h10;
  localparam int OFS_STAT  = 'h14;
  localparam int OFS_GLT   = 'h18;

  localparam int CB_RUN    = 3;
  localparam int CB_WAKEEN = 4;
  localparam int CB_IRQEN  = 7;
  localparam int CB_NSEC   = 11;
  localparam int CB_NVX    = 14;
  localparam int CB_INITX  = 15;

  localparam int SB_ALARM  = 3;
  localparam int SB_NVDONE = 14;
  localparam int SB_INIT   = 15;

  localparam logic [31:0] CTRL_MASK = 32'h0000_C898;
  localparam logic [31:0] GLT_MAGIC = 32'h4173_6166;
endpackage

// File: rtl/lp_rtc_wr_cdc.sv
`timescale 1ns/1ps
module lp_rtc_wr_cdc #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              bus_clk,
  input  logic              bus_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [DATA_W-1:0] hold_data,
  input  logic              lp_clk,
  input  logic              lp_rst,
  output logic              lp_stb
);
  logic req_t, ack_s1, ack_s2;
  logic req_s1, req_s2, req_s3;

  // bus side: capture and toggle request
  always_ff @(posedge bus_clk) begin
    if (bus_rst) begin
      req_t     <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
      ack_s1    <= 1'b0;
      ack_s2    <= 1'b0;
    end else begin
      ack_s1 <= req_s3;
      ack_s2 <= ack_s1;
      if (wr_en && !busy) begin
        hold_addr <= wr_addr;
        hold_data <= wr_data;
        req_t     <= ~req_t;
      end
    end
  end

  assign busy = req_t ^ ack_s2;

  // slow side: two-flop synchroniser plus edge detect
  always_ff @(posedge lp_clk) begin
    if (lp_rst) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
      req_s3 <= 1'b0;
    end else begin
      req_s1 <= req_t;
      req_s2 <= req_s1;
      req_s3 <= req_s2;
    end
  end

  assign lp_stb = req_s2 ^ req_s3;
endmodule

// File: rtl/lp_rtc_core.sv
`timescale 1ns/1ps
module lp_rtc_core
  import lp_rtc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int SUB_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] seconds,
  output logic [SUB_W-1:0]  subsec,
  output logic [DATA_W-1:0] alarm,
  output logic [DATA_W-1:0] ctrl,
  output logic [DATA_W-1:0] glitch,
  output logic [DATA_W-1:0] status,
  output logic              init_done,
  output logic              nv_done,
  output logic              alarm_flag,
  output logic              irq,
  output logic              wake
);
  logic w_sec, w_sub, w_alm, w_ctl, w_st, w_glt;
  logic run, match, match_q, init_req, nv_req;

  assign w_sec = wr_stb && (wr_addr == ADDR_W'(OFS_SEC));
  assign w_sub = wr_stb && (wr_addr == ADDR_W'(OFS_SUB));
  assign w_alm = wr_stb && (wr_addr == ADDR_W'(OFS_ALARM));
  assign w_ctl = wr_stb && (wr_addr == ADDR_W'(OFS_CTRL));
  assign w_st  = wr_stb && (wr_addr == ADDR_W'(OFS_STAT));
  assign w_glt = wr_stb && (wr_addr == ADDR_W'(OFS_GLT));

  assign init_req = w_ctl && wr_data[CB_INITX] && wr_data[CB_NSEC];
  assign nv_req   = w_ctl && init_done && (glitch == DATA_W'(GLT_MAGIC)) &&
                    wr_data[CB_INITX] && wr_data[CB_NVX] &&
                    wr_data[CB_NSEC]  && wr_data[CB_RUN];
  assign run   = nv_done && ctrl[CB_RUN];
  assign match = nv_done && (seconds == alarm);

  always_ff @(posedge clk) begin
    if (rst) begin
      seconds    <= '0;
      subsec     <= '0;
      alarm      <= '0;
      ctrl       <= '0;
      glitch     <= '0;
      init_done  <= 1'b0;
      nv_done    <= 1'b0;
      alarm_flag <= 1'b0;
      match_q    <= 1'b0;
      irq        <= 1'b0;
      wake       <= 1'b0;
    end else begin
      subsec <= w_sub ? wr_data[SUB_W-1:0] : subsec + 1'b1;
      if (w_sec)                 seconds <= wr_data;
      else if (run && &subsec)   seconds <= seconds + 1'b1;
      if (w_alm) alarm  <= wr_data;
      if (w_glt) glitch <= wr_data;
      if (w_ctl) ctrl   <= wr_data & DATA_W'(CTRL_MASK);
      if (init_req) init_done <= 1'b1;
      if (nv_req)   nv_done   <= 1'b1;
      match_q <= match;
      if (match && !match_q)          alarm_flag <= 1'b1;
      else if (w_st && wr_data[SB_ALARM]) alarm_flag <= 1'b0;
      irq  <= alarm_flag && ctrl[CB_IRQEN];
      wake <= alarm_flag && ctrl[CB_WAKEEN];
    end
  end

  always_comb begin
    status            = '0;
    status[SB_ALARM]  = alarm_flag;
    status[SB_NVDONE] = nv_done;
    status[SB_INIT]   = init_done;
  end
endmodule

// File: rtl/lp_rtc_mirror.sv
`timescale 1ns/1ps
module lp_rtc_mirror #(
  parameter int W = 32
) (
  input  logic         lp_clk,
  input  logic         lp_rst,
  input  logic [W-1:0] lp_val,
  input  logic         bus_clk,
  input  logic         bus_rst,
  output logic [W-1:0] bus_val
);
  logic tick, t1, t2, t3;

  always_ff @(posedge lp_clk) begin
    if (lp_rst) tick <= 1'b0;
    else        tick <= ~tick;
  end

  always_ff @(posedge bus_clk) begin
    if (bus_rst) begin
      t1      <= 1'b0;
      t2      <= 1'b0;
      t3      <= 1'b0;
      bus_val <= '0;
    end else begin
      t1 <= tick;
      t2 <= t1;
      t3 <= t2;
      if (t2 ^ t3) bus_val <= lp_val;
    end
  end
endmodule

// File: rtl/lp_rtc.sv
`timescale 1ns/1ps
module lp_rtc
  import lp_rtc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int SUB_W  = 15
) (
  input  logic              bus_clk,
  input  logic              bus_rst,
  input  logic              lp_clk,
  input  logic              lp_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_busy,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              alarm_irq,
  output logic              alarm_wake
);
  localparam int NREG  = 6;
  localparam int MIR_W = NREG * DATA_W;

  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;
  logic              lp_stb;
  logic [DATA_W-1:0] seconds, alarm, ctrl, glitch, status;
  logic [SUB_W-1:0]  subsec;
  logic              init_done, nv_done, alarm_flag;
  logic [MIR_W-1:0]  lp_snap, bus_snap;
  logic [DATA_W-1:0] m_sec, m_sub, m_alm, m_ctl, m_st, m_glt;

  lp_rtc_wr_cdc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(wr_busy), .hold_addr(hold_addr),
    .hold_data(hold_data), .lp_clk(lp_clk), .lp_rst(lp_rst), .lp_stb(lp_stb));

  lp_rtc_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SUB_W(SUB_W)) u_core (
    .clk(lp_clk), .rst(lp_rst), .wr_stb(lp_stb), .wr_addr(hold_addr),
    .wr_data(hold_data), .seconds(seconds), .subsec(subsec), .alarm(alarm),
    .ctrl(ctrl), .glitch(glitch), .status(status), .init_done(init_done),
    .nv_done(nv_done), .alarm_flag(alarm_flag), .irq(alarm_irq),
    .wake(alarm_wake));

  assign lp_snap = {DATA_W'(subsec), seconds, alarm, ctrl, status, glitch};

  lp_rtc_mirror #(.W(MIR_W)) u_mir (
    .lp_clk(lp_clk), .lp_rst(lp_rst), .lp_val(lp_snap),
    .bus_clk(bus_clk), .bus_rst(bus_rst), .bus_val(bus_snap));

  assign {m_sub, m_sec, m_alm, m_ctl, m_st, m_glt} = bus_snap;

  always_ff @(posedge bus_clk) begin
    if (bus_rst) rd_data <= '0;
    else if (rd_en) begin
      case (rd_addr)
        ADDR_W'(OFS_SEC):   rd_data <= m_sec;
        ADDR_W'(OFS_SUB):   rd_data <= m_sub;
        ADDR_W'(OFS_ALARM): rd_data <= m_alm;
        ADDR_W'(OFS_CTRL):  rd_data <= m_ctl;
        ADDR_W'(OFS_STAT):  rd_data <= m_st;
        ADDR_W'(OFS_GLT):   rd_data <= m_glt;
        default:            rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/lp_rtc_chk.sv
`timescale 1ns/1ps
module lp_rtc_chk #(
  parameter int DATA_W = 32,
  parameter int SUB_W  = 15
) (
  input logic              bus_clk,
  input logic              bus_rst,
  input logic              lp_clk,
  input logic              lp_rst,
  input logic              wr_en,
  input logic              wr_busy,
  input logic [DATA_W-1:0] hold_data,
  input logic              lp_stb,
  input logic [DATA_W-1:0] seconds,
  input logic [SUB_W-1:0]  subsec,
  input logic [DATA_W-1:0] ctrl,
  input logic              init_done,
  input logic              nv_done,
  input logic              alarm_flag,
  input logic              alarm_irq,
  input logic              alarm_wake
);
  assert_hold_stable_R2: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (wr_busy && wr_en) |=> $stable(hold_data));

  assert_busy_cause_R2: assert property (@(posedge bus_clk) disable iff (bus_rst)
    $rose(wr_busy) |-> $past(wr_en));

  assert_init_first_R5: assert property (@(posedge lp_clk) disable iff (lp_rst)
    $rose(nv_done) |-> $past(init_done));

  assert_init_sticky_R8: assert property (@(posedge lp_clk) disable iff (lp_rst)
    init_done |=> init_done);

  assert_nv_sticky_R8: assert property (@(posedge lp_clk) disable iff (lp_rst)
    nv_done |=> nv_done);

  assert_sub_step_R6: assert property (@(posedge lp_clk) disable iff (lp_rst)
    !lp_stb |=> (subsec == SUB_W'($past(subsec) + 1'b1)));

  assert_sec_hold_R6: assert property (@(posedge lp_clk) disable iff (lp_rst)
    (!lp_stb && !(nv_done && ctrl[3])) |=> $stable(seconds));

  assert_irq_follow_R9: assert property (@(posedge lp_clk) disable iff (lp_rst)
    (alarm_flag && ctrl[7]) |=> alarm_irq);

  assert_irq_quiet_R9: assert property (@(posedge lp_clk) disable iff (lp_rst)
    !(alarm_flag && ctrl[7]) |=> !alarm_irq);

  assert_wake_follow_R9: assert property (@(posedge lp_clk) disable iff (lp_rst)
    (alarm_flag && ctrl[4]) |=> alarm_wake);
endmodule

bind lp_rtc lp_rtc_chk #(.DATA_W(DATA_W), .SUB_W(SUB_W)) u_lp_rtc_chk (
  .bus_clk(bus_clk), .bus_rst(bus_rst), .lp_clk(lp_clk), .lp_rst(lp_rst),
  .wr_en(wr_en), .wr_busy(wr_busy), .hold_data(hold_data), .lp_stb(lp_stb),
  .seconds(seconds), .subsec(subsec), .ctrl(ctrl), .init_done(init_done),
  .nv_done(nv_done), .alarm_flag(alarm_flag), .alarm_irq(alarm_irq),
  .alarm_wake(alarm_wake));

// File: tb/test_lp_rtc.sv
`timescale 1ns/1ps
module test_lp_rtc;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int SW = 4;
  localparam int LP_RATIO = 12;                 // bus cycles per slow cycle
  localparam int SEC_CYC  = LP_RATIO * (1 << SW); // bus cycles per second

  logic bus_clk = 1'b0, lp_clk = 1'b0;
  logic bus_rst = 1'b1, lp_rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic wr_busy, alarm_irq, alarm_wake;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 bus_clk = ~bus_clk;
  always #30  lp_clk  = ~lp_clk;

  lp_rtc #(.ADDR_W(AW), .DATA_W(DW), .SUB_W(SW)) i_lp_rtc (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .lp_clk(lp_clk), .lp_rst(lp_rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_busy(wr_busy),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .alarm_irq(alarm_irq), .alarm_wake(alarm_wake));

  // register readback vectors (R3): offset, write value, expected read
  localparam int NV = 4;
  localparam logic [AW-1:0] V_ADDR [NV] = '{5'h08, 5'h00, 5'h18, 5'h10};
  localparam logic [DW-1:0] V_DATA [NV] =
    '{32'hDEAD_BEEF, 32'h0000_0050, 32'h1234_5678, 32'hFFFF_FFFF};
  localparam logic [DW-1:0] V_EXP  [NV] =
    '{32'hDEAD_BEEF, 32'h0000_0050, 32'h1234_5678, 32'h0000_C898};

  task automatic chk(input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge bus_clk);
    while (wr_busy) @(negedge bus_clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge bus_clk);
    wr_en = 1'b0;
    while (wr_busy) @(negedge bus_clk);
    repeat (3 * LP_RATIO) @(negedge bus_clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge bus_clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge bus_clk);
    d = rd_data;
    rd_en = 1'b0;
  endtask

  initial begin
    #900us;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v, v2;
    repeat (40) @(negedge bus_clk);
    bus_rst = 1'b0; lp_rst = 1'b0;
    repeat (4 * LP_RATIO) @(negedge bus_clk);

    // R1: reset state
    chk("R1 busy", DW'(wr_busy), 0);
    chk("R1 irq", DW'(alarm_irq), 0);
    chk("R1 wake", DW'(alarm_wake), 0);
    rd(5'h14, v); chk("R1 status", v, 0);
    rd(5'h10, v); chk("R1 ctrl", v, 0);
    rd(5'h00, v); chk("R1 seconds", v, 0);

    // R4: init-exit bit alone is not enough
    wr(5'h10, 32'h0000_8000);
    rd(5'h14, v); chk("R4 no exit without bit 11", v, 0);

    // R3: table of register writes and readbacks
    for (int i = 0; i < NV; i++) begin
      wr(V_ADDR[i], V_DATA[i]);
      rd(V_ADDR[i], v);
      chk($sformatf("R3 vector %0d", i), v, V_EXP[i]);
    end

    // R4 set by 0xFFFFFFFF control write; R5 blocked by wrong glitch value
    rd(5'h14, v); chk("R4/R5 init only", v, 32'h0000_8000);

    // R6: seconds held before non-valid exit
    rd(5'h00, v);
    repeat (SEC_CYC - 2) @(negedge bus_clk);
    rd(5'h00, v2); chk("R6 held", v2, v);

    // R2: write offered while busy is dropped
    @(negedge bus_clk);
    while (wr_busy) @(negedge bus_clk);
    wr_en = 1'b1; wr_addr = 5'h08; wr_data = 32'h1111_1111;
    @(negedge bus_clk);
    chk("R2 busy after accept", DW'(wr_busy), 1);
    wr_data = 32'h2222_2222;
    @(negedge bus_clk);
    wr_en = 1'b0;
    while (wr_busy) @(negedge bus_clk);
    repeat (3 * LP_RATIO) @(negedge bus_clk);
    rd(5'h08, v); chk("R2 second write ignored", v, 32'h1111_1111);

    // R5: correct glitch value then non-valid exit
    wr(5'h18, 32'h4173_6166);
    wr(5'h10, 32'h0000_C808);
    rd(5'h14, v); chk("R5 nv exit", v, 32'h0000_C000);

    // R6: sub-second steps and seconds run
    rd(5'h04, v);
    repeat (LP_RATIO - 2) @(negedge bus_clk);
    rd(5'h04, v2); chk("R6 subsec step", v2, (v + 1) & ((1 << SW) - 1));
    rd(5'h00, v);
    repeat (SEC_CYC - 2) @(negedge bus_clk);
    rd(5'h00, v2); chk("R6 seconds step", v2, v + 1);

    // R7 / R9: alarm with both enables
    wr(5'h10, 32'h0000_C898);
    wr(5'h00, 32'd100);
    wr(5'h08, 32'd103);
    rd(5'h14, v); chk("R7 flag not yet", v, 32'h0000_C000);
    chk("R9 irq low before match", DW'(alarm_irq), 0);
    repeat (5 * SEC_CYC) @(negedge bus_clk);
    rd(5'h14, v); chk("R7 flag set", v, 32'h0000_C008);
    chk("R9 irq", DW'(alarm_irq), 1);
    chk("R9 wake", DW'(alarm_wake), 1);

    // R8: W1C clears only the alarm flag
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, v); chk("R8 w1c", v, 32'h0000_C000);
    chk("R8 irq cleared", DW'(alarm_irq), 0);
    chk("R8 wake cleared", DW'(alarm_wake), 0);

    // R9: wake enable without interrupt enable
    wr(5'h10, 32'h0000_C818);
    rd(5'h00, v);
    wr(5'h08, v + 2);
    repeat (4 * SEC_CYC) @(negedge bus_clk);
    chk("R9 irq masked", DW'(alarm_irq), 0);
    chk("R9 wake only", DW'(alarm_wake), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule